// File: doc/BRIEF.md
# Vector Memory Transfer Lane Sequencer

This block sits between the issue stage and the memory pipeline of a vector unit with 16 lanes of 32 bits each. It takes one decoded vector load or store per instruction and turns it into memory requests. There are three addressing modes. In strided mode a lane's address is a base plus the lane number times a stride. In gather/scatter mode each lane's address comes from the matching lane of a pointer register. In block mode the register sits contiguously in memory.

A block instruction whose base address is a whole multiple of the register size goes out as one full-width request. When such a block is a store with every lane enabled, the request is marked as a full-line write, so a cache miss can allocate the line without reading its old contents. Every other instruction is walked out one lane per cycle over sixteen cycles, and each request carries its lane index. When the store buffer refuses a request, the same lane is offered again until it is taken, and the later lanes wait behind it. While an instruction is in progress, the sequencer holds the issue stage off through its busy output.

Top module: `vec_xfer_seq`

## Requirements
- R1: After reset, `busy` and `mem_valid` are low.
- R2: In strided mode (`req_mode` 1 or 3), lane i is requested with address `req_base + i*req_stride` and `mem_lane` = i. Lanes 0 to 15 go out in order, one per cycle, when `mem_ready` stays high.
- R3: In gather/scatter mode (`req_mode` 2), lane i is requested at the address held in `req_ptrs[i*32 +: 32]`.
- R4: A block instruction (`req_mode` 0) whose base has its low 6 bits at zero produces exactly one request. That request has `mem_wide` high, `mem_lane` 0, the base address, and `mem_data` equal to the whole register.
- R5: `mem_full_line` is high only on a full-width store whose 16 mask bits are all one. It stays low for a full-width load.
- R6: On a full-width request, `mem_wmask` equals the lane mask. A full-width store with any mask bit zero has `mem_full_line` low.
- R7: In the per-lane modes, a lane whose mask bit is zero raises no request in its cycle. It still takes its cycle, so the following lanes keep their slots.
- R8: When `mem_valid` is high and `mem_ready` is low, the next cycle shows the same lane, address and data. No later lane is requested until that lane is accepted. This holds for the last lane as well.
- R9: `busy` stays high from the cycle after acceptance until the final lane (index 15), or the single full-width request, has been accepted. An instruction presented while `busy` is high is ignored.
- R10: A block instruction whose base is not 64-byte aligned falls back to sixteen per-lane requests at `req_base + 4*i`.
- R11: On a per-lane request, `mem_data[31:0]` holds lane i's data and the upper bits are zero, while `mem_wmask` has only bit i set. On a full-width request, lane i's data sits at bits `[i*32 +: 32]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Instruction presented; accepted on a clock edge when busy is low |
| req_store | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | 0 block, 1 or 3 strided, 2 gather/scatter |
| req_base | input | 32 | Base byte address |
| req_stride | input | 32 | Byte stride for strided mode |
| req_ptrs | input | 512 | Per-lane addresses for gather/scatter |
| req_data | input | 512 | Register contents, lane i at [i*32 +: 32] |
| req_mask | input | 16 | Active lane mask |
| busy | output | 1 | Instruction in progress; issue must wait |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Request taken; low means rolled back |
| mem_wide | output | 1 | Full-register request |
| mem_store | output | 1 | Request is a store |
| mem_full_line | output | 1 | Store covers the whole line; no fill read needed |
| mem_addr | output | 32 | Request byte address |
| mem_lane | output | 4 | Lane index carried with the request |
| mem_data | output | 512 | Request data |
| mem_wmask | output | 16 | Lane byte-group enables |

## Verification
The bench builds the block with its defaults: 16 lanes of 32 bits and 32-bit addresses. With these values the 64-byte alignment boundary and the last lane index 15 are the ones the requirements name. Directed scenarios cover the cases at those boundaries: an aligned block against a base 4 bytes off, a rollback on a middle lane and on lane 15, and a second instruction arriving halfway through a sequence.

// File: rtl/vec_xfer_seq.sv
module vec_xfer_seq #(
  parameter int LANES  = 16,
  parameter int LANE_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_store,
  input  logic [1:0]                req_mode,
  input  logic [ADDR_W-1:0]         req_base,
  input  logic [ADDR_W-1:0]         req_stride,
  input  logic [LANES*ADDR_W-1:0]   req_ptrs,
  input  logic [LANES*LANE_W-1:0]   req_data,
  input  logic [LANES-1:0]          req_mask,
  output logic                      busy,
  output logic                      mem_valid,
  input  logic                      mem_ready,
  output logic                      mem_wide,
  output logic                      mem_store,
  output logic                      mem_full_line,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [$clog2(LANES)-1:0]  mem_lane,
  output logic [LANES*LANE_W-1:0]   mem_data,
  output logic [LANES-1:0]          mem_wmask
);
  localparam int IDX_W     = $clog2(LANES);
  localparam int REG_BYTES = LANES * LANE_W / 8;
  localparam int ALIGN_W   = $clog2(REG_BYTES);
  localparam int ELEM_B    = LANE_W / 8;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

  logic                     act, wide_r, store_r, scat_r;
  logic [IDX_W-1:0]         lane_r;
  logic [ADDR_W-1:0]        addr_r, stride_r;
  logic [LANES*ADDR_W-1:0]  ptrs_r;
  logic [LANES*LANE_W-1:0]  data_r;
  logic [LANES-1:0]         mask_r;

  wire accept  = req_valid && !act;
  wire aligned = (req_base[ALIGN_W-1:0] == '0);
  wire take    = !mem_valid || mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act      <= 1'b0;
      wide_r   <= 1'b0;
      store_r  <= 1'b0;
      scat_r   <= 1'b0;
      lane_r   <= '0;
      addr_r   <= '0;
      stride_r <= '0;
      ptrs_r   <= '0;
      data_r   <= '0;
      mask_r   <= '0;
    end else if (accept) begin
      act      <= 1'b1;
      wide_r   <= (req_mode == 2'd0) && aligned;
      store_r  <= req_store;
      scat_r   <= (req_mode == 2'd2);
      lane_r   <= '0;
      addr_r   <= req_base;
      stride_r <= (req_mode == 2'd0) ? ADDR_W'(ELEM_B) : req_stride;
      ptrs_r   <= req_ptrs;
      data_r   <= req_data;
      mask_r   <= req_mask;
    end else if (act && take) begin
      if (wide_r || lane_r == LAST) begin
        act <= 1'b0;
      end else begin
        lane_r <= lane_r + IDX_W'(1);
        addr_r <= addr_r + stride_r;
      end
    end
  end

  wire [LANE_W-1:0] lane_data = data_r[lane_r*LANE_W +: LANE_W];
  wire [ADDR_W-1:0] lane_ptr  = ptrs_r[lane_r*ADDR_W +: ADDR_W];

  assign busy          = act;
  assign mem_valid     = act && (wide_r ? |mask_r : mask_r[lane_r]);
  assign mem_wide      = wide_r;
  assign mem_store     = store_r;
  assign mem_full_line = mem_valid && wide_r && store_r && (&mask_r);
  assign mem_lane      = wide_r ? '0 : lane_r;
  assign mem_addr      = (scat_r && !wide_r) ? lane_ptr : addr_r;
  assign mem_data      = wide_r ? data_r : {{((LANES-1)*LANE_W){1'b0}}, lane_data};
  assign mem_wmask     = wide_r ? mask_r : (LANES'(1) << lane_r);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  assert_wide_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_wide |-> (mem_addr[ALIGN_W-1:0] == '0) && (mem_lane == '0));

  assert_full_line_only_full_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_full_line |-> mem_wide && mem_store && (&mem_wmask));

  assert_rollback_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_lane)
                                && $stable(mem_data));

  assert_lane_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_wide && (!mem_valid || mem_ready) && mem_lane != LAST
      |=> busy && (mem_lane == $past(mem_lane) + IDX_W'(1)));

  assert_busy_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mem_valid && mem_ready && (mem_wide || mem_lane == LAST) |=> !busy);
endmodule

// File: tb/sim_vec_xfer_seq.sv
module sim_vec_xfer_seq;
  localparam int L = 16, W = 32, A = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0;
  logic [1:0] req_mode = '0;
  logic [A-1:0] req_base = '0, req_stride = '0;
  logic [L*A-1:0] req_ptrs = '0;
  logic [L*W-1:0] req_data = '0;
  logic [L-1:0] req_mask = '0;
  logic busy, mem_valid, mem_wide, mem_store, mem_full_line;
  logic mem_ready = 1'b1;
  logic [A-1:0] mem_addr;
  logic [3:0] mem_lane;
  logic [L*W-1:0] mem_data;
  logic [L-1:0] mem_wmask;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  vec_xfer_seq u0 (.clk, .rst_n, .req_valid, .req_store, .req_mode, .req_base,
    .req_stride, .req_ptrs, .req_data, .req_mask, .busy, .mem_valid, .mem_ready,
    .mem_wide, .mem_store, .mem_full_line, .mem_addr, .mem_lane, .mem_data, .mem_wmask);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dlane(input int i);
    return 32'hA500_0000 + i * 32'h0101;
  endfunction

  task automatic issue(input logic [1:0] m, input logic st, input logic [31:0] b,
                       input logic [31:0] s, input logic [15:0] mk);
    @(negedge clk);
    req_mode = m; req_store = st; req_base = b; req_stride = s; req_mask = mk;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R1 busy after reset", 64'(busy), 0);
    chk(mem_valid == 1'b0, "R1 mem_valid after reset", 64'(mem_valid), 0);
  endtask

  task automatic t_strided;
    issue(2'd1, 1'b1, 32'h1000, 32'd12, 16'hFFFF);
    for (int i = 0; i < L; i++) begin
      chk(mem_valid && busy && !mem_wide, "R2 lane valid", {mem_valid, busy, mem_wide}, 3'b110);
      chk(mem_addr == 32'h1000 + i * 12, "R2 strided address", mem_addr, 32'h1000 + i * 12);
      chk(mem_lane == 4'(i), "R2 lane index", mem_lane, i);
      chk(mem_data[31:0] == dlane(i) && mem_data[L*W-1:32] == '0, "R11 lane data",
          mem_data[63:0], dlane(i));
      chk(mem_wmask == 16'(1 << i), "R11 lane wmask", mem_wmask, 16'(1 << i));
      if (i == 5) begin req_valid = 1'b1; req_base = 32'h7000; req_stride = 32'd4; end
      if (i == 9) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(!busy && !mem_valid, "R9 busy drops after lane 15, mid-run request ignored",
        {busy, mem_valid}, 0);
  endtask

  task automatic t_scatter;
    issue(2'd2, 1'b0, 32'h0, 32'd0, 16'hFFFF);
    for (int i = 0; i < L; i++) begin
      chk(mem_valid && mem_lane == 4'(i), "R3 gather lane", mem_lane, i);
      chk(mem_addr == 32'h8000 + (15 - i) * 16, "R3 gather address", mem_addr, 32'h8000 + (15 - i) * 16);
      @(negedge clk);
    end
    chk(!busy, "R9 busy after gather", busy, 0);
  endtask

  task automatic t_block(input logic st, input logic [15:0] mk, input bit exp_full);
    issue(2'd0, st, 32'h2000, 32'd0, mk);
    chk(mem_valid && mem_wide && mem_lane == 0, "R4 single wide request",
        {mem_valid, mem_wide, mem_lane}, 6'b110000);
    chk(mem_addr == 32'h2000, "R4 wide address", mem_addr, 32'h2000);
    chk(mem_data == req_data, "R11 wide data", mem_data[63:0], req_data[63:0]);
    chk(mem_wmask == mk, "R6 wide wmask", mem_wmask, mk);
    chk(mem_full_line == exp_full, "R5 R6 full line flag", mem_full_line, exp_full);
    @(negedge clk);
    chk(!busy && !mem_valid, "R4 only one request", {busy, mem_valid}, 0);
  endtask

  task automatic t_misaligned;
    issue(2'd0, 1'b1, 32'h2004, 32'd0, 16'hFFFF);
    for (int i = 0; i < L; i++) begin
      chk(mem_valid && !mem_wide && !mem_full_line, "R10 per-lane fallback",
          {mem_valid, mem_wide, mem_full_line}, 3'b100);
      chk(mem_addr == 32'h2004 + 4 * i, "R10 fallback address", mem_addr, 32'h2004 + 4 * i);
      @(negedge clk);
    end
    chk(!busy, "R10 fallback ends", busy, 0);
  endtask

  task automatic t_lane_mask;
    logic [15:0] mk = 16'h0F30;
    issue(2'd1, 1'b1, 32'h4000, 32'd8, mk);
    for (int i = 0; i < L; i++) begin
      chk(mem_valid == mk[i], "R7 masked lane no request", mem_valid, mk[i]);
      chk(busy && mem_lane == 4'(i), "R7 slot kept", mem_lane, i);
      if (mk[i]) chk(mem_addr == 32'h4000 + 8 * i, "R7 address", mem_addr, 32'h4000 + 8 * i);
      @(negedge clk);
    end
    chk(!busy, "R7 ends after 16 slots", busy, 0);
  endtask

  task automatic t_rollback;
    issue(2'd1, 1'b1, 32'h3000, 32'd8, 16'hFFFF);
    for (int i = 0; i < L; i++) begin
      chk(mem_lane == 4'(i) && mem_addr == 32'h3000 + 8 * i, "R8 lane before stall", mem_lane, i);
      if (i == 3 || i == 15) begin
        mem_ready = 1'b0;
        for (int k = 0; k < 2; k++) begin
          @(negedge clk);
          chk(mem_valid && mem_lane == 4'(i), "R8 same lane replayed", mem_lane, i);
          chk(mem_addr == 32'h3000 + 8 * i, "R8 same address", mem_addr, 32'h3000 + 8 * i);
          chk(mem_data[31:0] == dlane(i), "R8 same data", mem_data[31:0], dlane(i));
          chk(busy, "R9 busy held during rollback", busy, 1);
        end
        mem_ready = 1'b1;
      end
      @(negedge clk);
    end
    chk(!busy && !mem_valid, "R9 release after replayed last lane", {busy, mem_valid}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < L; i++) begin
      req_data[i*W +: W] = dlane(i);
      req_ptrs[i*A +: A] = 32'h8000 + (15 - i) * 16;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_strided();
    t_scatter();
    t_block(1'b1, 16'hFFFF, 1'b1);
    t_block(1'b1, 16'hFFF7, 1'b0);
    t_block(1'b0, 16'hFFFF, 1'b0);
    t_misaligned();
    t_lane_mask();
    t_rollback();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule